// File: doc/BRIEF.md
# ADC Continuous Scan Sequencer

This block sequences a multi-channel analog-to-digital converter in continuous scan mode. A start bit is set by a software write or by an external trigger pulse. While the bit stays set, the block walks the selected channel group in order. It keeps a request high to an abstract conversion engine and presents the channel index on the same cycle. Each returned result is stored in the result slot belonging to that channel. When the last selected channel has been converted, a completion flag is raised and the walk starts over at the group's first channel. There are no idle cycles between channels.

Software selects one of two groups of four channels and a channel count of one to four. The block samples the selection when the start bit goes from 0 to 1, so a start and a new selection may be written in the same cycle. Clearing the start bit abandons any conversion in progress. The next start always begins at the first channel of the group. The completion flag stays set until software clears it, and the interrupt request is the flag gated by the interrupt enable.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, start_o, conv_req_o, flag_o and irq_o are 0, and every result slot in res_o is 0.
- R2: A cycle with start_set_i or trig_i high, while the start bit is 0 and start_clr_i is low, sets start_o and conv_req_o on the next cycle. conv_ch_o then shows the group's first channel: 0 when grp_sel_i is 0 and 4 when grp_sel_i is 1.
- R3: ch_cnt_i values 0, 1, 2 and 3 select 1, 2, 3 and 4 channels. Group 0 covers channels 0 to 3 and group 1 covers channels 4 to 7. conv_ch_o is {group bit, slot}.
- R4: A conv_done_i pulse while the block is scanning and not the last channel moves conv_ch_o to the next channel on the next cycle. conv_req_o stays high throughout.
- R5: conv_data_i, accepted with conv_done_i, appears on the next cycle in res_o[s*DATA_W +: DATA_W]. Here s is the slot, which is the channel number modulo 4. The other slots keep their values.
- R6: conv_done_i on the last selected channel sets flag_o on the next cycle and returns conv_ch_o to the group's first channel.
- R7: irq_o is high exactly when flag_o and irq_en_i are both high.
- R8: flag_o stays set until a cycle with flag_clr_i high. If a pass completes in the same cycle as flag_clr_i, the flag stays set.
- R9: start_clr_i drops start_o and conv_req_o on the next cycle and takes priority over a start. A conv_done_i in that same cycle is discarded: no result slot and no flag change.
- R10: A restart after a halt begins at the group's first channel. Changes to grp_sel_i and ch_cnt_i while scanning have no effect until the next start.
- R11: conv_done_i while conv_req_o is low changes neither res_o nor flag_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_set_i | input | 1 | Software write of 1 to the start bit |
| trig_i | input | 1 | External trigger pulse that sets the start bit |
| start_clr_i | input | 1 | Software write of 0 to the start bit |
| grp_sel_i | input | 1 | Channel group select |
| ch_cnt_i | input | 2 | Number of channels minus one |
| irq_en_i | input | 1 | Interrupt enable |
| flag_clr_i | input | 1 | Software write of 0 to the completion flag |
| conv_done_i | input | 1 | Conversion engine done pulse |
| conv_data_i | input | DATA_W | Converted value returned with done |
| conv_req_o | output | 1 | Conversion request, high while scanning |
| conv_ch_o | output | 3 | Channel index being converted |
| start_o | output | 1 | Current value of the start bit |
| flag_o | output | 1 | Completion flag |
| irq_o | output | 1 | Interrupt request |
| res_o | output | 4*DATA_W | Result slots, slot s at bits s*DATA_W upward |

## Verification
On every cycle the assertions check the following. A start always lands on slot 0. The request never gaps after an accepted done. A clear always stops the request and freezes the results. The flag holds until it is cleared, and the interrupt never rises without the flag. Done pulses outside a scan leave the results alone. Only the bench scenarios can show the data-dependent parts: which slot receives each value, where each channel count wraps, the group offset, and that a selection changed mid-scan is ignored until the restart.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } scan_st_e;
endpackage

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_scan_pkg::*;
#(
  parameter int unsigned SLOT_W = 2,
  parameter int unsigned GRP_W  = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_set_i,
  input  logic              trig_i,
  input  logic              start_clr_i,
  input  logic [GRP_W-1:0]  grp_sel_i,
  input  logic [SLOT_W-1:0] ch_cnt_i,
  input  logic              conv_done_i,
  output logic              run_o,
  output logic [GRP_W-1:0]  grp_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              wr_en_o,
  output logic              pass_end_o
);
  scan_st_e          st_q;
  logic [GRP_W-1:0]  grp_q;
  logic [SLOT_W-1:0] last_q, slot_q;
  logic              go, accept;

  assign go         = (st_q == ST_IDLE) && (start_set_i || trig_i) && !start_clr_i;
  assign accept     = (st_q == ST_SCAN) && conv_done_i && !start_clr_i;
  assign pass_end_o = accept && (slot_q == last_q);
  assign wr_en_o    = accept;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      grp_q  <= '0;
      last_q <= '0;
      slot_q <= '0;
    end else if (start_clr_i) begin
      st_q   <= ST_IDLE;
      slot_q <= '0;
    end else if (go) begin
      // selection sampled only at the start edge
      st_q   <= ST_SCAN;
      grp_q  <= grp_sel_i;
      last_q <= ch_cnt_i;
      slot_q <= '0;
    end else if (accept) begin
      slot_q <= pass_end_o ? '0 : slot_q + 1'b1;
    end
  end

  assign run_o  = (st_q == ST_SCAN);
  assign grp_o  = grp_q;
  assign slot_o = slot_q;
endmodule

// File: rtl/adc_scan_results.sv
module adc_scan_results #(
  parameter int unsigned DATA_W = 10,
  parameter int unsigned GRP_CH = 4,
  localparam int unsigned SLOT_W = $clog2(GRP_CH)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [SLOT_W-1:0]        slot_i,
  input  logic [DATA_W-1:0]        data_i,
  output logic [GRP_CH*DATA_W-1:0] res_o
);
  for (genvar s = 0; s < GRP_CH; s++) begin : g_slot
    logic [DATA_W-1:0] res_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  res_q <= '0;
      else if (wr_en_i && slot_i == SLOT_W'(s))     res_q <= data_i;
    end
    assign res_o[s*DATA_W +: DATA_W] = res_q;
  end
endmodule

// File: rtl/adc_scan_flag.sv
module adc_scan_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic irq_en_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;   // completion beats software clear
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & irq_en_i;
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
  parameter int unsigned DATA_W  = 10,
  parameter int unsigned GRP_CH  = 4,
  parameter int unsigned NUM_GRP = 2,
  localparam int unsigned SLOT_W = $clog2(GRP_CH),
  localparam int unsigned GRP_W  = $clog2(NUM_GRP),
  localparam int unsigned CH_W   = SLOT_W + GRP_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_set_i,
  input  logic                     trig_i,
  input  logic                     start_clr_i,
  input  logic [GRP_W-1:0]         grp_sel_i,
  input  logic [SLOT_W-1:0]        ch_cnt_i,
  input  logic                     irq_en_i,
  input  logic                     flag_clr_i,
  input  logic                     conv_done_i,
  input  logic [DATA_W-1:0]        conv_data_i,
  output logic                     conv_req_o,
  output logic [CH_W-1:0]          conv_ch_o,
  output logic                     start_o,
  output logic                     flag_o,
  output logic                     irq_o,
  output logic [GRP_CH*DATA_W-1:0] res_o
);
  logic              run, wr_en, pass_end;
  logic [GRP_W-1:0]  grp;
  logic [SLOT_W-1:0] slot;

  adc_scan_ctrl #(.SLOT_W(SLOT_W), .GRP_W(GRP_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_set_i (start_set_i),
    .trig_i      (trig_i),
    .start_clr_i (start_clr_i),
    .grp_sel_i   (grp_sel_i),
    .ch_cnt_i    (ch_cnt_i),
    .conv_done_i (conv_done_i),
    .run_o       (run),
    .grp_o       (grp),
    .slot_o      (slot),
    .wr_en_o     (wr_en),
    .pass_end_o  (pass_end)
  );

  adc_scan_results #(.DATA_W(DATA_W), .GRP_CH(GRP_CH)) u_res (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en),
    .slot_i  (slot),
    .data_i  (conv_data_i),
    .res_o   (res_o)
  );

  adc_scan_flag u_flag (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (pass_end),
    .clr_i    (flag_clr_i),
    .irq_en_i (irq_en_i),
    .flag_o   (flag_o),
    .irq_o    (irq_o)
  );

  assign conv_req_o = run;
  assign start_o    = run;
  assign conv_ch_o  = {grp, slot};
endmodule

// File: rtl/adc_scan_sva.sv
module adc_scan_sva #(
  parameter int unsigned DATA_W  = 10,
  parameter int unsigned GRP_CH  = 4,
  parameter int unsigned NUM_GRP = 2,
  localparam int unsigned SLOT_W = $clog2(GRP_CH),
  localparam int unsigned GRP_W  = $clog2(NUM_GRP),
  localparam int unsigned CH_W   = SLOT_W + GRP_W
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     start_set_i,
  input logic                     trig_i,
  input logic                     start_clr_i,
  input logic [GRP_W-1:0]         grp_sel_i,
  input logic [SLOT_W-1:0]        ch_cnt_i,
  input logic                     irq_en_i,
  input logic                     flag_clr_i,
  input logic                     conv_done_i,
  input logic [DATA_W-1:0]        conv_data_i,
  input logic                     conv_req_o,
  input logic [CH_W-1:0]          conv_ch_o,
  input logic                     start_o,
  input logic                     flag_o,
  input logic                     irq_o,
  input logic [GRP_CH*DATA_W-1:0] res_o
);
  assert_start_slot0_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(conv_req_o) |-> conv_ch_o[SLOT_W-1:0] == '0);

  assert_no_gap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_req_o && conv_done_i && !start_clr_i) |=> conv_req_o);

  assert_irq_needs_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_o |-> !irq_o);

  assert_flag_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !flag_clr_i) |=> flag_o);

  assert_clr_stops_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_clr_i |=> (!conv_req_o && !start_o && $stable(res_o)));

  assert_idle_done_ignored_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!conv_req_o && conv_done_i) |=> $stable(res_o));
endmodule

bind adc_scan_seq adc_scan_sva #(.DATA_W(DATA_W), .GRP_CH(GRP_CH), .NUM_GRP(NUM_GRP)) u_sva (.*);

// File: tb/tb_adc_scan_seq.sv
module tb_adc_scan_seq;
  localparam int DW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_set = 0, trig = 0, start_clr = 0, grp_sel = 0;
  logic [1:0]    ch_cnt = 0;
  logic          irq_en = 0, flag_clr = 0, conv_done = 0;
  logic [DW-1:0] conv_data = 0;
  logic          conv_req, start, flag, irq;
  logic [2:0]    conv_ch;
  logic [4*DW-1:0] res;

  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  adc_scan_seq #(.DATA_W(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_set_i(start_set), .trig_i(trig),
    .start_clr_i(start_clr), .grp_sel_i(grp_sel), .ch_cnt_i(ch_cnt),
    .irq_en_i(irq_en), .flag_clr_i(flag_clr), .conv_done_i(conv_done),
    .conv_data_i(conv_data), .conv_req_o(conv_req), .conv_ch_o(conv_ch),
    .start_o(start), .flag_o(flag), .irq_o(irq), .res_o(res)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  function automatic logic [DW-1:0] slot_val(input int s);
    return res[s*DW +: DW];
  endfunction

  task automatic convert(input logic [DW-1:0] d);
    conv_done = 1; conv_data = d; step(); conv_done = 0;
  endtask

  task automatic go(input logic g, input logic [1:0] c, input logic use_trig);
    grp_sel = g; ch_cnt = c;
    if (use_trig) trig = 1; else start_set = 1;
    step(); trig = 0; start_set = 0;
  endtask

  task automatic halt();
    start_clr = 1; step(); start_clr = 0;
  endtask

  task automatic clear_flag();
    flag_clr = 1; step(); flag_clr = 0;
  endtask

  task automatic t_reset();
    chk("R1 start", start, 0);
    chk("R1 req", conv_req, 0);
    chk("R1 flag", flag, 0);
    chk("R1 irq", irq, 0);
    chk("R1 res", res, 0);
  endtask

  task automatic t_scan3();
    irq_en = 1;
    go(0, 2'b10, 0);
    chk("R2 start", start, 1);
    chk("R2 req", conv_req, 1);
    chk("R2 ch", conv_ch, 0);
    convert(10'd101);
    chk("R4 ch", conv_ch, 1);
    chk("R4 req", conv_req, 1);
    chk("R5 slot0", slot_val(0), 101);
    chk("R6 flag early", flag, 0);
    convert(10'd102);
    chk("R4 ch2", conv_ch, 2);
    chk("R5 slot1", slot_val(1), 102);
    convert(10'd103);
    chk("R6 flag", flag, 1);
    chk("R6 wrap", conv_ch, 0);
    chk("R3 3ch slot2", slot_val(2), 103);
    chk("R3 slot3 untouched", slot_val(3), 0);
    chk("R7 irq on", irq, 1);
    irq_en = 0; #1;
    chk("R7 irq gated", irq, 0);
    irq_en = 1;
  endtask

  task automatic t_flag();
    repeat (3) step();
    chk("R8 flag hold", flag, 1);
    convert(10'd201);
    convert(10'd202);
    flag_clr = 1; convert(10'd203); flag_clr = 0;
    chk("R8 set beats clr", flag, 1);
    clear_flag();
    chk("R8 cleared", flag, 0);
    chk("R7 irq off", irq, 0);
  endtask

  task automatic t_halt_restart();
    convert(10'd301);                    // slot0, now on ch1
    chk("R4 ch1", conv_ch, 1);
    start_clr = 1; conv_done = 1; conv_data = 10'd999;
    step();
    start_clr = 0; conv_done = 0;
    chk("R9 start", start, 0);
    chk("R9 req", conv_req, 0);
    chk("R9 slot1 kept", slot_val(1), 202);
    chk("R9 flag kept", flag, 0);
    convert(10'd777);
    chk("R11 slot0 kept", slot_val(0), 301);
    chk("R11 flag", flag, 0);
    go(1, 2'b00, 1);
    chk("R2 trig start", start, 1);
    chk("R3 group1 first", conv_ch, 4);
    grp_sel = 0; ch_cnt = 2'b11;          // ignored while running
    convert(10'd401);
    chk("R3 1ch flag", flag, 1);
    chk("R10 sel ignored", conv_ch, 4);
    chk("R5 group1 slot0", slot_val(0), 401);
    clear_flag();
    halt();
    start_clr = 1; start_set = 1; step(); start_clr = 0; start_set = 0;
    chk("R9 clr priority", start, 0);
  endtask

  task automatic t_scan4();
    go(0, 2'b11, 0);
    chk("R10 restart first", conv_ch, 0);
    for (int i = 0; i < 4; i++) begin
      chk("R3 4ch order", conv_ch, i);
      chk("R6 no flag mid", flag, 0);
      convert(DW'(500 + i));
    end
    chk("R6 flag 4ch", flag, 1);
    chk("R6 wrap 4ch", conv_ch, 0);
    for (int i = 0; i < 4; i++) chk("R5 4ch slots", slot_val(i), 500 + i);
    clear_flag();
    go(0, 2'b01, 0);                      // already running: no effect
    convert(10'd600);
    chk("R10 no restart", conv_ch, 1);
    halt();
    go(0, 2'b01, 0);
    chk("R10 restart slot0", conv_ch, 0);
    convert(10'd610);
    convert(10'd611);
    chk("R3 2ch flag", flag, 1);
    chk("R3 2ch wrap", conv_ch, 0);
  endtask

  initial begin
    #20; t_reset();
    @(negedge clk); rst_n = 1; step();
    t_reset();
    t_scan3();
    t_flag();
    t_halt_restart();
    t_scan4();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule